// File: doc/BRIEF.md
# Interprocessor Mailbox Hub

This block is a register-mapped target that holds a configurable number of independent mailboxes, up to 256. Processors use them to signal each other. Every mailbox has a 16-bit command word, a 16-bit data word, one reserved slot and a pending flag. A sender writes the data word and then the command word. The command write stores the word and also sets the pending flag. The flag drives one of `NIRQ` interrupt outputs toward the receiving processor. The receiver reads the command and data words, then writes any value to the flag slot to acknowledge the interrupt.

Addresses on both channels are word addresses. Bits [1:0] select the slot inside a mailbox: 0 is the command word, 1 is the data word, 2 is reserved and 3 is the pending flag. The bits above them select the mailbox, so each mailbox spans four words (16 bytes). Mailbox `i` drives interrupt line `i mod NIRQ`. Each line is the OR of the flags of every mailbox mapped to it. `N_WP` independent write channels can land in the same cycle, for example from two processors on separate ports. One read channel returns its word in the cycle after the request.

Top module: `mbox_irq_hub`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every command word, data word and pending flag is 0, `irq_o` is 0 and `rd_data_o` is 0.
- R2: A write to slot 0 (command) stores the 16-bit word. A read of slot 0 returns that word zero-extended to `BUS_W` bits on `rd_data_o` one clock after `rd_en_i` is sampled.
- R3: A write to slot 0 of mailbox `i` sets its pending flag, and `irq_o[i mod NIRQ]` is 1 from the clock edge that samples the write. No interrupt line rises in a cycle without such a write.
- R4: A write to slot 1 (data) stores the 16-bit word and a read returns it zero-extended. The write leaves the pending flag and `irq_o` unchanged.
- R5: A write to slot 2 (reserved) changes no stored value and no output, and a read of slot 2 returns 0.
- R6: A read of slot 3 returns 1 while the flag is set and 0 while it is clear, with all upper bits 0. A write of any value to slot 3 clears the flag.
- R7: Clearing one mailbox leaves its interrupt line high while another mailbox mapped to the same line is still pending.
- R8: If one channel writes slot 0 and another writes slot 3 of the same mailbox in the same cycle, the flag ends up set, whichever channel carries which write.
- R9: If several channels write the same command or data word in the same cycle, the value from the lowest-numbered channel is stored.
- R10: An access to a mailbox index at or above `N_MBOX` is ignored: writes change nothing and reads return 0.
- R11: A read of a word in the same cycle it is written returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | N_WP | Write strobe, one per write channel |
| wr_addr_i | input | N_WP x ADDR_W | Word address per write channel: mailbox index above, slot in bits [1:0] |
| wr_data_i | input | N_WP x WORD_W | Write word per channel |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | BUS_W | Read word, valid the cycle after `rd_en_i` |
| irq_o | output | NIRQ | Interrupt lines; line k is the OR of flags of mailboxes i with i mod NIRQ = k |

## Verification
The two functions that collide are the flag set caused by a command write and the flag clear caused by an acknowledge write. They can only meet in one cycle when two write channels target the same mailbox. The bench provokes this with the command on channel 0 and the clear on channel 1, then with the roles swapped. After each attempt it checks that the interrupt line is high and that a read of the flag slot returns 1. A second overlap, two channels writing the same word, is judged by reading back the word and expecting channel 0's value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    OFF_CMD  = 2'd0,
    OFF_DATA = 2'd1,
    OFF_RSVD = 2'd2,
    OFF_FLAG = 2'd3
  } mbox_off_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mbox_wr_decode.sv
module mbox_wr_decode
  import mbox_pkg::*;
#(
  parameter int unsigned N_MBOX = 6,
  parameter int unsigned IDX_W  = 3,
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_MBOX-1:0] cmd_sel_o,
  output logic [N_MBOX-1:0] data_sel_o,
  output logic [N_MBOX-1:0] clr_sel_o
);

  logic [IDX_W-1:0] idx;
  mbox_off_e        off;
  logic             hit;

  assign idx = addr_i[ADDR_W-1:2];
  assign off = mbox_off_e'(addr_i[1:0]);
  assign hit = en_i && ({1'b0, idx} < (IDX_W+1)'(N_MBOX));

  for (genvar i = 0; i < N_MBOX; i++) begin : g_sel
    logic me;
    assign me            = hit && (idx == IDX_W'(i));
    assign cmd_sel_o[i]  = me && (off == OFF_CMD);
    assign data_sel_o[i] = me && (off == OFF_DATA);
    assign clr_sel_o[i]  = me && (off == OFF_FLAG);
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned N_WP   = 2,
  parameter int unsigned WORD_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_WP-1:0]             cmd_we_i,
  input  logic [N_WP-1:0]             data_we_i,
  input  logic [N_WP-1:0]             clr_we_i,
  input  logic [N_WP-1:0][WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0]           cmd_o,
  output logic [WORD_W-1:0]           data_o,
  output logic                        pend_o
);

  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              pend_q, pend_d;

  // walk high to low so the lowest channel lands last and wins
  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    for (int p = N_WP - 1; p >= 0; p--) begin
      if (cmd_we_i[p])  cmd_d  = wdata_i[p];
      if (data_we_i[p]) data_d = wdata_i[p];
    end
  end

  // set dominates clear
  always_comb begin
    pend_d = pend_q;
    if (|clr_we_i) pend_d = 1'b0;
    if (|cmd_we_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      pend_q <= pend_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/mbox_irq_map.sv
module mbox_irq_map #(
  parameter int unsigned N_MBOX = 6,
  parameter int unsigned NIRQ   = 4
) (
  input  logic [N_MBOX-1:0] pend_i,
  output logic [NIRQ-1:0]   irq_o
);

  for (genvar l = 0; l < NIRQ; l++) begin : g_line
    logic [N_MBOX-1:0] mask;
    for (genvar i = 0; i < N_MBOX; i++) begin : g_mb
      if ((i % NIRQ) == l) begin : g_on
        assign mask[i] = pend_i[i];
      end else begin : g_off
        assign mask[i] = 1'b0;
      end
    end
    assign irq_o[l] = |mask;
  end

endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux
  import mbox_pkg::*;
#(
  parameter int unsigned N_MBOX = 6,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [N_MBOX-1:0][WORD_W-1:0] cmd_i,
  input  logic [N_MBOX-1:0][WORD_W-1:0] data_i,
  input  logic [N_MBOX-1:0]             pend_i,
  output logic [BUS_W-1:0]              rd_data_o
);

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [BUS_W-1:0] word_d, word_q;

  assign idx      = rd_addr_i[ADDR_W-1:2];
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(N_MBOX));

  always_comb begin
    word_d = '0;
    if (in_range) begin
      unique case (mbox_off_e'(rd_addr_i[1:0]))
        OFF_CMD:  word_d = BUS_W'(cmd_i[idx]);
        OFF_DATA: word_d = BUS_W'(data_i[idx]);
        OFF_FLAG: word_d = BUS_W'(pend_i[idx]);
        default:  word_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (rd_en_i) word_q <= word_d;
  end

  assign rd_data_o = word_q;

endmodule

// File: rtl/mbox_irq_hub.sv
module mbox_irq_hub #(
  parameter int unsigned N_MBOX = 6,
  parameter int unsigned NIRQ   = 4,
  parameter int unsigned N_WP   = 2,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned IDX_W  = mbox_pkg::idx_w(N_MBOX),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_WP-1:0]             wr_en_i,
  input  logic [N_WP-1:0][ADDR_W-1:0] wr_addr_i,
  input  logic [N_WP-1:0][WORD_W-1:0] wr_data_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [BUS_W-1:0]            rd_data_o,
  output logic [NIRQ-1:0]             irq_o
);

  logic [N_WP-1:0][N_MBOX-1:0]   cmd_sel, data_sel, clr_sel;
  logic [N_MBOX-1:0][N_WP-1:0]   cmd_we, data_we, clr_we;
  logic [N_MBOX-1:0][WORD_W-1:0] cmd_q, data_q;
  logic [N_MBOX-1:0]             pend_q;

  for (genvar p = 0; p < N_WP; p++) begin : g_port
    mbox_wr_decode #(
      .N_MBOX (N_MBOX),
      .IDX_W  (IDX_W)
    ) u_dec (
      .en_i       (wr_en_i[p]),
      .addr_i     (wr_addr_i[p]),
      .cmd_sel_o  (cmd_sel[p]),
      .data_sel_o (data_sel[p]),
      .clr_sel_o  (clr_sel[p])
    );
  end

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mb
    for (genvar p = 0; p < N_WP; p++) begin : g_xp
      assign cmd_we[i][p]  = cmd_sel[p][i];
      assign data_we[i][p] = data_sel[p][i];
      assign clr_we[i][p]  = clr_sel[p][i];
    end

    mbox_slot #(
      .N_WP   (N_WP),
      .WORD_W (WORD_W)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_we_i  (cmd_we[i]),
      .data_we_i (data_we[i]),
      .clr_we_i  (clr_we[i]),
      .wdata_i   (wr_data_i),
      .cmd_o     (cmd_q[i]),
      .data_o    (data_q[i]),
      .pend_o    (pend_q[i])
    );
  end

  mbox_irq_map #(
    .N_MBOX (N_MBOX),
    .NIRQ   (NIRQ)
  ) u_irq (
    .pend_i (pend_q),
    .irq_o  (irq_o)
  );

  mbox_rd_mux #(
    .N_MBOX (N_MBOX),
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W),
    .BUS_W  (BUS_W)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cmd_i     (cmd_q),
    .data_i    (data_q),
    .pend_i    (pend_q),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/mbox_irq_hub_chk.sv
module mbox_irq_hub_chk #(
  parameter int unsigned N_MBOX = 6,
  parameter int unsigned NIRQ   = 4,
  parameter int unsigned N_WP   = 2,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BUS_W  = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_WP-1:0]             wr_en_i,
  input logic [N_WP-1:0][ADDR_W-1:0] wr_addr_i,
  input logic                        rd_en_i,
  input logic [ADDR_W-1:0]           rd_addr_i,
  input logic [BUS_W-1:0]            rd_data_o,
  input logic [NIRQ-1:0]             irq_o
);

  logic [NIRQ-1:0]  cmd_line;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_oor;

  always_comb begin
    cmd_line = '0;
    for (int p = 0; p < N_WP; p++) begin
      for (int l = 0; l < NIRQ; l++) begin
        if (wr_en_i[p] && (wr_addr_i[p][1:0] == 2'd0) &&
            ({1'b0, wr_addr_i[p][ADDR_W-1:2]} < (IDX_W+1)'(N_MBOX)) &&
            ((int'(wr_addr_i[p][ADDR_W-1:2]) % NIRQ) == l))
          cmd_line[l] = 1'b1;
      end
    end
  end

  assign rd_idx = rd_addr_i[ADDR_W-1:2];
  assign rd_oor = ({1'b0, rd_idx} >= (IDX_W+1)'(N_MBOX));

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && rd_data_o == '0)); // R1

  AST_CMD_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_line != '0) |=> ((irq_o & $past(cmd_line)) == $past(cmd_line))); // R3 R8

  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_line == '0) |=> ((irq_o & ~$past(irq_o)) == '0)); // R3

  AST_WORD_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_addr_i[1]) |=> (rd_data_o[BUS_W-1:16] == '0)); // R2

  AST_FLAG_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[1:0] == 2'd3) |=> (rd_data_o[BUS_W-1:1] == '0)); // R6

  AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[1:0] == 2'd2) |=> (rd_data_o == '0)); // R5

  AST_OOR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_oor) |=> (rd_data_o == '0)); // R10

endmodule

bind mbox_irq_hub mbox_irq_hub_chk #(
  .N_MBOX (N_MBOX),
  .NIRQ   (NIRQ),
  .N_WP   (N_WP),
  .IDX_W  (IDX_W),
  .ADDR_W (ADDR_W),
  .BUS_W  (BUS_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/mbox_irq_hub_test.sv
module mbox_irq_hub_test;

  localparam int unsigned AW = 5;

  logic                clk = 1'b0;
  logic                rst_ni;
  logic [1:0]          wr_en;
  logic [1:0][AW-1:0]  wr_addr;
  logic [1:0][15:0]    wr_data;
  logic                rd_en;
  logic [AW-1:0]       rd_addr;
  logic [31:0]         rd_data;
  logic [3:0]          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mbox_irq_hub #(
    .N_MBOX (6),
    .NIRQ   (4),
    .N_WP   (2),
    .WORD_W (16),
    .BUS_W  (32)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [2:0]  widx;
    logic [1:0]  woff;
    logic [15:0] wdat;
    logic [2:0]  ridx;
    logic [1:0]  roff;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
  } vec_t;

  // slots: 0 cmd, 1 data, 2 reserved, 3 flag; mailbox i -> line i%4
  localparam vec_t VEC [20] = '{
    '{4'd11, 1'b1, 3'd0, 2'd0, 16'h1234, 3'd0, 2'd0, 32'h0000_0000, 4'b0001}, // R11 R3
    '{4'd2,  1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd0, 32'h0000_1234, 4'b0001}, // R2
    '{4'd6,  1'b1, 3'd0, 2'd1, 16'hBEEF, 3'd0, 2'd3, 32'h0000_0001, 4'b0001}, // R6 R4
    '{4'd6,  1'b1, 3'd0, 2'd3, 16'h0000, 3'd0, 2'd1, 32'h0000_BEEF, 4'b0000}, // R6 R4
    '{4'd2,  1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd0, 32'h0000_1234, 4'b0000}, // R2
    '{4'd6,  1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd3, 32'h0000_0000, 4'b0000}, // R6
    '{4'd5,  1'b1, 3'd0, 2'd2, 16'h7777, 3'd0, 2'd2, 32'h0000_0000, 4'b0000}, // R5
    '{4'd5,  1'b0, 3'd0, 2'd0, 16'h0000, 3'd0, 2'd0, 32'h0000_1234, 4'b0000}, // R5
    '{4'd3,  1'b1, 3'd4, 2'd0, 16'h00AA, 3'd4, 2'd0, 32'h0000_0000, 4'b0001}, // R3
    '{4'd3,  1'b1, 3'd0, 2'd0, 16'h0055, 3'd4, 2'd3, 32'h0000_0001, 4'b0001}, // R3
    '{4'd7,  1'b1, 3'd4, 2'd3, 16'hFFFF, 3'd0, 2'd3, 32'h0000_0001, 4'b0001}, // R7
    '{4'd7,  1'b1, 3'd0, 2'd3, 16'h0000, 3'd4, 2'd0, 32'h0000_00AA, 4'b0000}, // R7
    '{4'd3,  1'b1, 3'd5, 2'd0, 16'h0101, 3'd5, 2'd1, 32'h0000_0000, 4'b0010}, // R3
    '{4'd3,  1'b1, 3'd3, 2'd0, 16'h0303, 3'd5, 2'd0, 32'h0000_0101, 4'b1010}, // R3
    '{4'd10, 1'b1, 3'd6, 2'd0, 16'h0666, 3'd6, 2'd0, 32'h0000_0000, 4'b1010}, // R10
    '{4'd10, 1'b1, 3'd7, 2'd1, 16'h0777, 3'd7, 2'd1, 32'h0000_0000, 4'b1010}, // R10
    '{4'd6,  1'b1, 3'd5, 2'd3, 16'h0000, 3'd3, 2'd3, 32'h0000_0001, 4'b1000}, // R6
    '{4'd6,  1'b1, 3'd3, 2'd3, 16'h0000, 3'd0, 2'd0, 32'h0000_0055, 4'b0000}, // R6 R2
    '{4'd4,  1'b1, 3'd2, 2'd1, 16'h1111, 3'd2, 2'd3, 32'h0000_0000, 4'b0000}, // R4
    '{4'd4,  1'b0, 3'd0, 2'd0, 16'h0000, 3'd2, 2'd1, 32'h0000_1111, 4'b0000}  // R4
  };

  function automatic logic [AW-1:0] ad(input int idx, input int off);
    return AW'((idx << 2) | off);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs change 1 ns after a rising edge; results sampled 1 ns after the next
  task automatic step(input logic we0, input logic [AW-1:0] a0, input logic [15:0] d0,
                      input logic we1, input logic [AW-1:0] a1, input logic [15:0] d1,
                      input logic re, input logic [AW-1:0] ra);
    wr_en      = {we1, we0};
    wr_addr[0] = a0;
    wr_addr[1] = a1;
    wr_data[0] = d0;
    wr_data[1] = d1;
    rd_en      = re;
    rd_addr    = ra;
    @(posedge clk);
    #1;
    wr_en = '0;
    rd_en = 1'b0;
  endtask

  task automatic rd(input int idx, input int off);
    step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, ad(idx, off));
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    rst_ni  = 1'b0;
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
    rd_en   = 1'b0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rd_data in reset", rd_data, 32'h0);
    chk("R1", "irq in reset", {28'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    rd(0, 0);
    chk("R1", "cmd after reset", rd_data, 32'h0);
    rd(0, 3);
    chk("R1", "flag after reset", rd_data, 32'h0);

    for (int k = 0; k < 20; k++) begin
      step(VEC[k].we, ad(VEC[k].widx, VEC[k].woff), VEC[k].wdat,
           1'b0, '0, '0, 1'b1, ad(VEC[k].ridx, VEC[k].roff));
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vector %0d rd_data", k),
          rd_data, VEC[k].exp_rd);
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vector %0d irq", k),
          {28'h0, irq}, {28'h0, VEC[k].exp_irq});
    end

    // R8: command on channel 0, clear on channel 1, same mailbox
    step(1'b1, ad(1, 0), 16'h0011, 1'b1, ad(1, 3), 16'h0000, 1'b0, '0);
    chk("R8", "irq cmd p0 / clr p1", {28'h0, irq}, 32'h2);
    rd(1, 3);
    chk("R8", "flag cmd p0 / clr p1", rd_data, 32'h1);
    step(1'b1, ad(1, 3), 16'h0000, 1'b0, '0, '0, 1'b0, '0);
    chk("R6", "irq after clear", {28'h0, irq}, 32'h0);
    // R8: roles swapped
    step(1'b1, ad(1, 3), 16'h0000, 1'b1, ad(1, 0), 16'h0022, 1'b0, '0);
    chk("R8", "irq clr p0 / cmd p1", {28'h0, irq}, 32'h2);
    rd(1, 3);
    chk("R8", "flag clr p0 / cmd p1", rd_data, 32'h1);
    rd(1, 0);
    chk("R8", "cmd from p1", rd_data, 32'h0000_0022);
    step(1'b0, '0, '0, 1'b1, ad(1, 3), 16'h5A5A, 1'b0, '0);
    chk("R6", "clear via p1", {28'h0, irq}, 32'h0);

    // R9: both channels hit one word
    step(1'b1, ad(2, 0), 16'h00A0, 1'b1, ad(2, 0), 16'h00B0, 1'b0, '0);
    chk("R3", "irq line 2", {28'h0, irq}, 32'h4);
    rd(2, 0);
    chk("R9", "cmd collision", rd_data, 32'h0000_00A0);
    step(1'b1, ad(3, 1), 16'h0A0A, 1'b1, ad(3, 1), 16'h0B0B, 1'b0, '0);
    rd(3, 1);
    chk("R9", "data collision", rd_data, 32'h0000_0A0A);
    step(1'b0, '0, '0, 1'b1, ad(3, 1), 16'h0C0C, 1'b0, '0);
    rd(3, 1);
    chk("R4", "data via p1", rd_data, 32'h0000_0C0C);
    chk("R4", "data leaves irq", {28'h0, irq}, 32'h4);
    step(1'b1, ad(2, 3), 16'h1234, 1'b0, '0, '0, 1'b0, '0);
    chk("R6", "clear line 2", {28'h0, irq}, 32'h0);

    // R1: reset in the middle of a run
    step(1'b1, ad(5, 0), 16'h0505, 1'b0, '0, '0, 1'b0, '0);
    chk("R3", "irq line 1", {28'h0, irq}, 32'h2);
    rst_ni = 1'b0;
    #1;
    chk("R1", "irq drops in reset", {28'h0, irq}, 32'h0);
    @(posedge clk);
    #1;
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    rd(5, 0);
    chk("R1", "cmd cleared by reset", rd_data, 32'h0);
    rd(3, 1);
    chk("R1", "data cleared by reset", rd_data, 32'h0);
    rd(5, 3);
    chk("R1", "flag cleared by reset", rd_data, 32'h0);

    summary();
    $finish;
  end

endmodule